// File: doc/BRIEF.md
# Watchdog and Reset Sequencer

This block is the chip's reset controller. It combines a fixed-period watchdog with the sequencer that decides when the processor core may run. Everything runs from one clock, the crystal-domain clock. The active-high reset pin goes through a two-stage synchronizer and then a glitch filter. While the pin is accepted, the core is held in reset and the configuration registers are forced to their defaults.

When the pin is released, a fixed reset timer runs. A short pre-boot window follows, during which firmware may take early actions, and then the core runs normally. In that normal state the watchdog counts cycles. Firmware must refresh it before it overflows.

An overflow starts the same timer and pre-boot sequence as a pin reset, with one difference: the configuration registers keep their contents. A sticky flag tells firmware which kind of reset happened last. While the emulator-enable input is high, the watchdog is switched off.

Top module: `wdt_reset_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, `core_rst`=1, `cfg_clear`=1, `preboot`=0 and `wdt_cause`=0.
- R2: A pin pulse that is high for fewer than FILT_CYC consecutive clock edges has no effect: no reset starts and `wdt_cause` keeps its value. A pulse of FILT_CYC edges or more is accepted as a reset.
- R3: While an accepted pin reset is active, `core_rst`=1, `cfg_clear`=1 and `preboot`=0.
- R4: After the pin falls, `core_rst` stays high for exactly RST_CYC+3 clock cycles. This is 2 cycles of synchronizer, 1 cycle of filter and RST_CYC cycles of reset timer.
- R5: Once `core_rst` falls, `preboot` is high for exactly PRE_CYC cycles. After that, `core_rst` and `preboot` are both low, which is the run state.
- R6: With no refresh, `core_rst` rises exactly WDT_LIM cycles after the first run cycle.
- R7: A one-cycle `wdt_kick` in the run state restarts the count. Refreshes spaced no more than WDT_LIM cycles apart prevent any reset.
- R8: A refresh that arrives while `core_rst` or `preboot` is high is ignored. The count always starts from zero when the core enters the run state.
- R9: A watchdog reset holds `core_rst` high for exactly RST_CYC cycles, then gives PRE_CYC cycles of `preboot`. `cfg_clear` stays low throughout.
- R10: `wdt_cause` becomes 1 on a watchdog overflow. It stays 1 until a pin reset is accepted, which clears it to 0.
- R11: While `emu_en`=1, no watchdog reset occurs and the count is held at zero. After `emu_en` falls in the run state, `core_rst` rises after WDT_LIM-1 cycles without refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-domain clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin | input | 1 | Asynchronous active-high external reset pin |
| wdt_kick | input | 1 | Watchdog refresh strobe from firmware |
| emu_en | input | 1 | Emulator enable; disables the watchdog |
| core_rst | output | 1 | Reset to the processor core, active high |
| cfg_clear | output | 1 | Forces configuration registers to defaults |
| preboot | output | 1 | Pre-boot window active |
| wdt_cause | output | 1 | Last reset came from the watchdog |

## Verification
The bench measures the exact length of each phase: pin release to core release, the pre-boot window, and the watchdog timeout. An off-by-one in any counter or in the synchronizer pipeline shows up as a wrong cycle count. Pin pulses one edge short of the filter threshold are injected between random refresh gaps; a filter that is too eager would start a spurious reset and clear the cause flag.

Refreshes held through reset and pre-boot expose a watchdog that counts or listens outside the run state, because the timeout would come out shorter or longer. A watchdog reset is watched for any pulse of `cfg_clear`, which would wrongly erase configuration. A long emulator-enable period checks that the timeout restarts cleanly when emulation ends, instead of firing at once from a stale count.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_TIMER = 2'd1,
    ST_PRE   = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/wrs_pin_filter.sv
module wrs_pin_filter #(
  parameter int FILT_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic pin_act
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          sync1, sync2;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      run_cnt <= '0;
    end else begin
      sync1 <= pin_raw;
      sync2 <= sync1;
      if (!sync2)
        run_cnt <= '0;
      else if (run_cnt != CW'(FILT_CYC))
        run_cnt <= run_cnt + 1'b1;
    end
  end

  assign pin_act = (run_cnt == CW'(FILT_CYC));

  AST_FILT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= CW'(FILT_CYC)); // R2
  AST_FILT_LOW_DROPS: assert property (@(posedge clk) disable iff (rst)
    !sync2 |=> !pin_act); // R2
endmodule

// File: rtl/wrs_wdt_counter.sv
module wrs_wdt_counter #(
  parameter int WDT_LIM = 49152
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic kick,
  input  logic emu_en,
  output logic ovf
);
  localparam int WW = $clog2(WDT_LIM + 1);

  logic [WW-1:0] wcnt;

  assign ovf = run && !emu_en && !kick && (wcnt == WW'(WDT_LIM - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || emu_en || kick || ovf)
      wcnt <= '0;
    else
      wcnt <= wcnt + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wcnt < WW'(WDT_LIM)); // R6
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (run && kick) |=> (wcnt == '0)); // R7
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !run |=> (wcnt == '0)); // R8
endmodule

// File: rtl/wrs_seq.sv
module wrs_seq
  import wrs_pkg::*;
#(
  parameter int RST_CYC = 4096,
  parameter int PRE_CYC = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_act,
  input  logic       wdt_ovf,
  output logic       run,
  output logic       core_rst,
  output logic       cfg_clear,
  output logic       preboot,
  output logic       wdt_cause
);
  localparam int MAXC = (RST_CYC > PRE_CYC) ? RST_CYC : PRE_CYC;
  localparam int SW   = $clog2(MAXC + 1);

  seq_state_t    st, st_nx;
  logic [SW-1:0] cnt, cnt_nx;
  logic          cause_nx;

  always_comb begin
    st_nx    = st;
    cnt_nx   = cnt + 1'b1;
    cause_nx = wdt_cause;
    case (st)
      ST_HOLD: begin
        cnt_nx = '0;
        if (!pin_act) st_nx = ST_TIMER;
      end
      ST_TIMER: begin
        if (cnt == SW'(RST_CYC - 1)) begin
          st_nx  = ST_PRE;
          cnt_nx = '0;
        end
      end
      ST_PRE: begin
        if (cnt == SW'(PRE_CYC - 1)) begin
          st_nx  = ST_RUN;
          cnt_nx = '0;
        end
      end
      default: begin
        cnt_nx = '0;
        if (wdt_ovf) begin
          st_nx    = ST_TIMER;
          cause_nx = 1'b1;
        end
      end
    endcase
    if (pin_act) begin
      st_nx    = ST_HOLD;
      cnt_nx   = '0;
      cause_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_TIMER;
      cnt       <= '0;
      wdt_cause <= 1'b0;
      core_rst  <= 1'b1;
      cfg_clear <= 1'b1;
      preboot   <= 1'b0;
    end else begin
      st        <= st_nx;
      cnt       <= cnt_nx;
      wdt_cause <= cause_nx;
      core_rst  <= (st_nx == ST_HOLD) || (st_nx == ST_TIMER);
      cfg_clear <= (st_nx == ST_HOLD);
      preboot   <= (st_nx == ST_PRE);
    end
  end

  assign run = (st == ST_RUN);

  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    pin_act |=> (core_rst && cfg_clear && !preboot)); // R3
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wdt_cause && !pin_act) |=> wdt_cause); // R10
  AST_WDT_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
    (wdt_ovf && !pin_act) |=> !cfg_clear); // R9
  AST_PRE_FOLLOWS_TIMER: assert property (@(posedge clk) disable iff (rst)
    $rose(preboot) |-> $past(st == ST_TIMER)); // R5
endmodule

// File: rtl/wdt_reset_seq.sv
module wdt_reset_seq #(
  parameter int FILT_CYC = 2,
  parameter int RST_CYC  = 4096,
  parameter int PRE_CYC  = 32,
  parameter int WDT_LIM  = 49152
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_pin,
  input  logic wdt_kick,
  input  logic emu_en,
  output logic core_rst,
  output logic cfg_clear,
  output logic preboot,
  output logic wdt_cause
);
  logic pin_act;
  logic run;
  logic wdt_ovf;

  wrs_pin_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk     (clk),
    .rst     (rst),
    .pin_raw (rst_pin),
    .pin_act (pin_act)
  );

  wrs_wdt_counter #(.WDT_LIM(WDT_LIM)) u_wdt (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .kick   (wdt_kick),
    .emu_en (emu_en),
    .ovf    (wdt_ovf)
  );

  wrs_seq #(.RST_CYC(RST_CYC), .PRE_CYC(PRE_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .pin_act   (pin_act),
    .wdt_ovf   (wdt_ovf),
    .run       (run),
    .core_rst  (core_rst),
    .cfg_clear (cfg_clear),
    .preboot   (preboot),
    .wdt_cause (wdt_cause)
  );

  AST_EMU_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    emu_en |-> !wdt_ovf); // R11
  AST_POR_STATE: assert property (@(posedge clk)
    rst |=> (core_rst && cfg_clear && !preboot && !wdt_cause)); // R1
endmodule

// File: tb/sim_wdt_reset_seq.sv
module sim_wdt_reset_seq;
  localparam int FILT = 4;
  localparam int RSTC = 40;
  localparam int PREC = 8;
  localparam int LIM  = 200;

  logic clk = 1'b0;
  logic rst, rst_pin, wdt_kick, emu_en;
  logic core_rst, cfg_clear, preboot, wdt_cause;
  int checks = 0;
  int failures = 0;
  int cfg_hits = 0;

  always #4 clk = ~clk;

  wdt_reset_seq #(.FILT_CYC(FILT), .RST_CYC(RSTC), .PRE_CYC(PREC), .WDT_LIM(LIM)) u0 (
    .clk(clk), .rst(rst), .rst_pin(rst_pin), .wdt_kick(wdt_kick), .emu_en(emu_en),
    .core_rst(core_rst), .cfg_clear(cfg_clear), .preboot(preboot), .wdt_cause(wdt_cause)
  );

  function automatic int exp_release();  return RSTC + 3; endfunction
  function automatic int exp_timeout();  return LIM;      endfunction
  function automatic int exp_emu_drop(); return LIM - 1;  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int which);
    return (which == 0) ? core_rst : preboot;
  endfunction

  task automatic run_len(input int which, input logic lvl, output int n);
    n = 0;
    while (sig(which) == lvl && n < 100000) begin
      if (cfg_clear) cfg_hits++;
      n++;
      step();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    int bad;
    void'($urandom(32'd1234));
    rst = 1'b1; rst_pin = 1'b0; wdt_kick = 1'b0; emu_en = 1'b0;
    repeat (3) step();
    // R1 power-on state
    chk(core_rst && cfg_clear && !preboot && !wdt_cause, "R1", {core_rst, cfg_clear, preboot, wdt_cause}, 4'b1100);
    rst = 1'b0;
    wdt_kick = 1'b1;                       // R8: refresh held through boot
    while (core_rst || preboot) step();
    wdt_kick = 1'b0;
    run_len(0, 1'b0, n);
    chk(n == exp_timeout(), "R8 R6 timeout", n, exp_timeout());
    chk(wdt_cause == 1'b1, "R10 cause set", wdt_cause, 1);
    cfg_hits = 0;
    run_len(0, 1'b1, n);
    chk(n == RSTC, "R9 wdt reset length", n, RSTC);
    run_len(1, 1'b1, n);
    chk(n == PREC, "R5 preboot length", n, PREC);
    chk(cfg_hits == 0, "R9 cfg kept", cfg_hits, 0);

    // R7 / R2: random refresh gaps with sub-threshold pin glitches
    bad = 0;
    for (int it = 0; it < 40; it++) begin
      int gap;
      int gl;
      gap = $urandom_range(FILT + 4, LIM / 2);
      gl  = ($urandom_range(0, 1) == 1) ? $urandom_range(1, FILT - 1) : 0;
      for (int c = 0; c < gap; c++) begin
        rst_pin = (c < gl);
        step();
        if (core_rst || preboot) bad++;
      end
      rst_pin = 1'b0;
      wdt_kick = 1'b1;
      step();
      wdt_kick = 1'b0;
      if (core_rst || preboot) bad++;
    end
    chk(bad == 0, "R7 refresh keeps alive", bad, 0);
    chk(wdt_cause == 1'b1, "R2 glitch ignored", wdt_cause, 1);

    // R11 emulator enable
    emu_en = 1'b1;
    bad = 0;
    for (int c = 0; c < 3 * LIM; c++) begin
      step();
      if (core_rst) bad++;
    end
    chk(bad == 0, "R11 no reset while emu", bad, 0);
    emu_en = 1'b0;
    step();
    run_len(0, 1'b0, n);
    chk(n == exp_emu_drop(), "R11 timeout after emu", n, exp_emu_drop());
    while (core_rst || preboot) step();

    // R3 R4 R10 pin reset
    rst_pin = 1'b1;
    repeat (20) step();
    chk(core_rst && cfg_clear && !preboot, "R3 pin hold", {core_rst, cfg_clear, preboot}, 3'b110);
    chk(wdt_cause == 1'b0, "R10 pin clears cause", wdt_cause, 0);
    rst_pin = 1'b0;
    step();
    run_len(0, 1'b1, n);
    chk(n == exp_release(), "R4 release timing", n, exp_release());
    run_len(1, 1'b1, n);
    chk(n == PREC, "R5 preboot after pin", n, PREC);
    chk(!core_rst && !preboot && !cfg_clear, "R5 run state", {core_rst, preboot, cfg_clear}, 0);

    // R2 minimum accepted pulse
    bad = 0;
    rst_pin = 1'b1;
    repeat (FILT) step();
    rst_pin = 1'b0;
    for (int c = 0; c < 10; c++) begin
      step();
      if (core_rst) bad++;
    end
    chk(bad > 0, "R2 threshold pulse accepted", bad, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule